// File: doc/BRIEF.md
# Per-Source Software Interrupt Pending Tracker

This block holds the pending state of software-generated interrupts for a small multiprocessor interrupt controller. It keeps one pending bit for every combination of interrupt number, destination CPU and originating CPU. Each destination therefore holds a bitmap of requesting CPUs for every software interrupt number.

A raise operation names an originating CPU, an interrupt number and a mask of destination CPUs. It marks every selected destination in one clock cycle. A retire operation names one originating CPU, an interrupt number and a destination mask. It removes only that originator's bit at each masked destination, so an interrupt that other originators still request stays pending.

A purely combinational lookup takes an interrupt ID and a destination CPU. It returns whether that interrupt is pending and which originator to present, which is the lowest-numbered originator still requesting it. IDs beyond the software range hold no state here and always read back as not pending with originator 0.

Top module: `swirq_pend_track`

## Requirements
- R1: A clock edge with `rst_n` low clears every pending bit, so every lookup then returns `q_pend`=0 and `q_src`=0.
- R2: With `set_en` high at an edge, the bit for (`set_sgi`, t, `set_src`) is set for every destination t whose bit is 1 in `set_tgt_mask`, and the lookup shows it after that single edge.
- R3: Pending bits of different originators, destinations and interrupt numbers are independent. A raise changes no bit outside its own number, its own originator and its masked destinations.
- R4: With `clr_en` high at an edge, only the bit of originator `clr_src` for number `clr_sgi` is cleared at each masked destination. The interrupt stays pending there while any other originator's bit is still set.
- R5: A retire processes every destination in `clr_tgt_mask` in the same single edge, including an all-ones mask, and leaves unmasked destinations untouched.
- R6: When several originators have a number pending at one destination, `q_src` is the lowest originator index whose bit is set.
- R7: For `q_id` >= 16 (numbers 0..15 are the software range, and `q_id` equals the number there), `q_pend` is 0 and `q_src` is 0 whatever the stored state.
- R8: If a raise and a retire address the same (number, destination, originator) triple at one edge, the bit ends up set.
- R9: `q_pend` and `q_src` follow `q_id` and `q_tgt` combinationally in the same cycle, with no clock edge needed.
- R10: `q_pend` is the OR of the addressed originator bitmap, and `q_src` is 0 whenever `q_pend` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| set_en | input | 1 | Raise strobe |
| set_src | input | 3 | Originating CPU of the raise |
| set_sgi | input | 4 | Software interrupt number to raise |
| set_tgt_mask | input | 8 | Destination CPUs of the raise, bit t = CPU t |
| clr_en | input | 1 | Retire strobe |
| clr_src | input | 3 | Originating CPU whose request is retired |
| clr_sgi | input | 4 | Software interrupt number to retire |
| clr_tgt_mask | input | 8 | Destination CPUs of the retire, bit t = CPU t |
| q_id | input | 10 | Interrupt ID to look up |
| q_tgt | input | 3 | Destination CPU to look up |
| q_pend | output | 1 | Looked-up interrupt is pending |
| q_src | output | 3 | Lowest pending originator of the looked-up interrupt |

## Verification
Raises and retires land on the next rising edge, and lookups are combinational on the stored bits. The bench therefore drives each operation just after a falling edge and drops the strobes one falling edge later. It then sweeps all numbers and destinations while the stored state is still, and compares each lookup a fixed delay after the query inputs change. The same-cycle lookup case changes `q_tgt` twice within one low clock phase and samples before the next rising edge, which shows that no register sits on the lookup path.

// File: rtl/swirq_pkg.sv
package swirq_pkg;
   localparam int MAX_CPU = 8;
   localparam int MAX_SGI = 16;
endpackage

// File: rtl/swirq_low_enc.sv
module swirq_low_enc #(
   parameter int W  = 8,
   parameter int IW = 3
) (
   input  logic [W-1:0]  vec,
   output logic [IW-1:0] idx
);
   generate
      if (W == 1) begin : g_single
         assign idx = '0;
      end else begin : g_scan
         always_comb begin
            idx = '0;
            for (int i = W - 1; i >= 0; i--) begin
               if (vec[i]) idx = IW'(i);
            end
         end
      end
   endgenerate
endmodule

// File: rtl/swirq_src_row.sv
module swirq_src_row #(
   parameter int W  = 8,
   parameter int IW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          set_hit,
   input  logic [IW-1:0] set_src,
   input  logic          clr_hit,
   input  logic [IW-1:0] clr_src,
   output logic [W-1:0]  bits
);
   logic [W-1:0] set_vec;
   logic [W-1:0] clr_vec;

   always_comb begin
      set_vec = '0;
      clr_vec = '0;
      for (int i = 0; i < W; i++) begin
         if (set_hit && int'(set_src) == i) set_vec[i] = 1'b1;
         if (clr_hit && int'(clr_src) == i) clr_vec[i] = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) bits <= '0;
      else        bits <= (bits & ~clr_vec) | set_vec;
   end
endmodule

// File: rtl/swirq_pend_track.sv
module swirq_pend_track #(
   parameter int NUM_CPU = 8,
   parameter int NUM_SGI = 16,
   parameter int ID_W    = 10,
   localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
   localparam int SGI_W  = (NUM_SGI > 1) ? $clog2(NUM_SGI) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               set_en,
   input  logic [CPU_W-1:0]   set_src,
   input  logic [SGI_W-1:0]   set_sgi,
   input  logic [NUM_CPU-1:0] set_tgt_mask,
   input  logic               clr_en,
   input  logic [CPU_W-1:0]   clr_src,
   input  logic [SGI_W-1:0]   clr_sgi,
   input  logic [NUM_CPU-1:0] clr_tgt_mask,
   input  logic [ID_W-1:0]    q_id,
   input  logic [CPU_W-1:0]   q_tgt,
   output logic               q_pend,
   output logic [CPU_W-1:0]   q_src
);
   localparam int ROWS   = NUM_SGI * NUM_CPU;
   localparam int FLAT_W = ROWS * NUM_CPU;

   generate
      if (NUM_CPU < 1 || NUM_CPU > swirq_pkg::MAX_CPU) begin : g_bad_cpu
         $error("NUM_CPU out of range");
      end
      if (NUM_SGI < 2 || NUM_SGI > swirq_pkg::MAX_SGI || (1 << SGI_W) != NUM_SGI) begin : g_bad_sgi
         $error("NUM_SGI must be a power of two up to the maximum");
      end
      if (ID_W <= SGI_W || ID_W > 31) begin : g_bad_id
         $error("ID_W must exceed the number width and fit an int");
      end
   endgenerate

   logic [NUM_CPU-1:0] row_bits [ROWS];
   logic [FLAT_W-1:0]  pend_flat;

   genvar s, t;
   generate
      for (s = 0; s < NUM_SGI; s++) begin : g_sgi
         for (t = 0; t < NUM_CPU; t++) begin : g_tgt
            localparam int IDX = s * NUM_CPU + t;
            logic set_hit;
            logic clr_hit;
            assign set_hit = set_en && (int'(set_sgi) == s) && set_tgt_mask[t];
            assign clr_hit = clr_en && (int'(clr_sgi) == s) && clr_tgt_mask[t];
            swirq_src_row #(.W(NUM_CPU), .IW(CPU_W)) u_row (
               .clk     (clk),
               .rst_n   (rst_n),
               .set_hit (set_hit),
               .set_src (set_src),
               .clr_hit (clr_hit),
               .clr_src (clr_src),
               .bits    (row_bits[IDX])
            );
            assign pend_flat[IDX*NUM_CPU +: NUM_CPU] = row_bits[IDX];
         end
      end
   endgenerate

   logic               q_in_range;
   logic [NUM_CPU-1:0] q_row;

   always_comb begin
      q_in_range = (int'(q_id) < NUM_SGI) && (int'(q_tgt) < NUM_CPU);
      q_row      = '0;
      if (q_in_range) q_row = row_bits[int'(q_id[SGI_W-1:0]) * NUM_CPU + int'(q_tgt)];
   end

   swirq_low_enc #(.W(NUM_CPU), .IW(CPU_W)) u_enc (
      .vec (q_row),
      .idx (q_src)
   );

   assign q_pend = |q_row;
endmodule

// File: rtl/swirq_pend_track_chk.sv
module swirq_pend_track_chk #(
   parameter int NUM_CPU = 8,
   parameter int NUM_SGI = 16,
   parameter int ID_W    = 10,
   parameter int CPU_W   = 3,
   parameter int SGI_W   = 4
) (
   input logic                               clk,
   input logic                               rst_n,
   input logic                               set_en,
   input logic [CPU_W-1:0]                   set_src,
   input logic [SGI_W-1:0]                   set_sgi,
   input logic [NUM_CPU-1:0]                 set_tgt_mask,
   input logic                               clr_en,
   input logic [CPU_W-1:0]                   clr_src,
   input logic [SGI_W-1:0]                   clr_sgi,
   input logic [NUM_CPU-1:0]                 clr_tgt_mask,
   input logic [ID_W-1:0]                    q_id,
   input logic [CPU_W-1:0]                   q_tgt,
   input logic                               q_pend,
   input logic [CPU_W-1:0]                   q_src,
   input logic [NUM_SGI*NUM_CPU*NUM_CPU-1:0] pend_flat
);
   function automatic int fidx(int sg, int tg, int sr);
      return (sg * NUM_CPU + tg) * NUM_CPU + sr;
   endfunction

   logic               chk_in;
   logic [NUM_CPU-1:0] chk_row;
   logic [NUM_CPU-1:0] chk_below;

   always_comb begin
      chk_in  = (int'(q_id) < NUM_SGI) && (int'(q_tgt) < NUM_CPU);
      chk_row = '0;
      if (chk_in) chk_row = pend_flat[fidx(int'(q_id[SGI_W-1:0]), int'(q_tgt), 0) +: NUM_CPU];
      chk_below = (NUM_CPU'(1) << q_src) - NUM_CPU'(1);
   end

   assert_reset_clears_R1: assert property (@(posedge clk)
      !rst_n |=> pend_flat == '0);

   genvar t;
   generate
      for (t = 0; t < NUM_CPU; t++) begin : g_t
         // R2 and R8: a raise always leaves its bit set, even against a retire
         assert_raise_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
            set_en && set_tgt_mask[t] |=>
               pend_flat[fidx(int'($past(set_sgi)), t, int'($past(set_src)))]);

         assert_retire_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
            clr_en && clr_tgt_mask[t] &&
            !(set_en && set_tgt_mask[t] && set_sgi == clr_sgi && set_src == clr_src) |=>
               !pend_flat[fidx(int'($past(clr_sgi)), t, int'($past(clr_src)))]);
      end
   endgenerate

   assert_lowest_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
      q_pend |-> chk_row[q_src] && ((chk_row & chk_below) == '0));

   assert_out_of_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
      int'(q_id) >= NUM_SGI |-> !q_pend && q_src == '0);

   assert_pend_is_or_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (q_pend == (|chk_row)) && (q_pend || q_src == '0));
endmodule

bind swirq_pend_track swirq_pend_track_chk #(
   .NUM_CPU (NUM_CPU),
   .NUM_SGI (NUM_SGI),
   .ID_W    (ID_W),
   .CPU_W   (CPU_W),
   .SGI_W   (SGI_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .set_en       (set_en),
   .set_src      (set_src),
   .set_sgi      (set_sgi),
   .set_tgt_mask (set_tgt_mask),
   .clr_en       (clr_en),
   .clr_src      (clr_src),
   .clr_sgi      (clr_sgi),
   .clr_tgt_mask (clr_tgt_mask),
   .q_id         (q_id),
   .q_tgt        (q_tgt),
   .q_pend       (q_pend),
   .q_src        (q_src),
   .pend_flat    (pend_flat)
);

// File: tb/test_swirq_pend_track.sv
`timescale 1ns/1ps
module test_swirq_pend_track;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       set_en = 1'b0;
   logic [2:0] set_src = '0;
   logic [3:0] set_sgi = '0;
   logic [7:0] set_tgt_mask = '0;
   logic       clr_en = 1'b0;
   logic [2:0] clr_src = '0;
   logic [3:0] clr_sgi = '0;
   logic [7:0] clr_tgt_mask = '0;
   logic [9:0] q_id = '0;
   logic [2:0] q_tgt = '0;
   logic       q_pend;
   logic [2:0] q_src;

   int total = 0;
   int bad   = 0;
   logic [7:0] model [16][8];

   always #2 clk = ~clk;

   swirq_pend_track i_swirq_pend_track (
      .clk(clk), .rst_n(rst_n),
      .set_en(set_en), .set_src(set_src), .set_sgi(set_sgi), .set_tgt_mask(set_tgt_mask),
      .clr_en(clr_en), .clr_src(clr_src), .clr_sgi(clr_sgi), .clr_tgt_mask(clr_tgt_mask),
      .q_id(q_id), .q_tgt(q_tgt), .q_pend(q_pend), .q_src(q_src)
   );

   function automatic logic [2:0] lowest(logic [7:0] v);
      for (int b = 0; b < 8; b++) if (v[b]) return 3'(b);
      return 3'd0;
   endfunction

   task automatic check(string tag, logic ap, logic [2:0] as, logic ep, logic [2:0] es);
      total++;
      if (ap !== ep || as !== es) begin
         bad++;
         $display("FAIL %s id=%0d tgt=%0d got pend=%0b src=%0d exp pend=%0b src=%0d",
                  tag, q_id, q_tgt, ap, as, ep, es);
      end
   endtask

   task automatic sweep(string tag);
      for (int id = 0; id < 16; id++) begin
         for (int t = 0; t < 8; t++) begin
            q_id = 10'(id); q_tgt = 3'(t);
            #0.1;
            check(tag, q_pend, q_src, |model[id][t], lowest(model[id][t]));
         end
      end
   endtask

   task automatic op(logic se, logic [2:0] ss, logic [3:0] sg, logic [7:0] sm,
                     logic ce, logic [2:0] cs, logic [3:0] cg, logic [7:0] cm);
      @(negedge clk);
      set_en = se; set_src = ss; set_sgi = sg; set_tgt_mask = sm;
      clr_en = ce; clr_src = cs; clr_sgi = cg; clr_tgt_mask = cm;
      @(negedge clk);
      set_en = 1'b0; clr_en = 1'b0;
      for (int t = 0; t < 8; t++) begin
         if (ce && cm[t]) model[cg][t][cs] = 1'b0;
         if (se && sm[t]) model[sg][t][ss] = 1'b1;
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < 16; i++) for (int t = 0; t < 8; t++) model[i][t] = '0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      do_reset();
      sweep("R1 after reset");

      // R2 / R3: one raise to several destinations, others untouched
      op(1, 3'd4, 4'd7, 8'b1010_0101, 0, 0, 0, 0);
      sweep("R2 R3 single raise");

      // R6: sources 5 and 2 at number 3, destination 1
      op(1, 3'd5, 4'd3, 8'b0000_0010, 0, 0, 0, 0);
      op(1, 3'd2, 4'd3, 8'b0000_0010, 0, 0, 0, 0);
      q_id = 10'd3; q_tgt = 3'd1; #0.1;
      check("R6 lowest of 2,5", q_pend, q_src, 1'b1, 3'd2);

      // R4: retire source 2 leaves source 5 pending
      op(0, 0, 0, 0, 1, 3'd2, 4'd3, 8'b0000_0010);
      q_id = 10'd3; q_tgt = 3'd1; #0.1;
      check("R4 other source stays", q_pend, q_src, 1'b1, 3'd5);
      op(0, 0, 0, 0, 1, 3'd5, 4'd3, 8'b0000_0010);
      q_id = 10'd3; q_tgt = 3'd1; #0.1;
      check("R4 last source retired", q_pend, q_src, 1'b0, 3'd0);

      // R5: all-ones retire in one edge
      op(1, 3'd1, 4'd9, 8'hFF, 0, 0, 0, 0);
      op(1, 3'd6, 4'd9, 8'hFF, 0, 0, 0, 0);
      op(0, 0, 0, 0, 1, 3'd1, 4'd9, 8'hFF);
      sweep("R5 all-ones retire");

      // R8: raise and retire on the same triple
      op(1, 3'd0, 4'd12, 8'b0100_0000, 1, 3'd0, 4'd12, 8'b0100_0001);
      q_id = 10'd12; q_tgt = 3'd6; #0.1;
      check("R8 raise wins", q_pend, q_src, 1'b1, 3'd0);
      sweep("R8 R5 collision");

      // R7: IDs above the software range
      op(1, 3'd3, 4'd0, 8'hFF, 0, 0, 0, 0);
      foreach (model[i]) begin end
      for (int k = 0; k < 4; k++) begin
         q_id = (k == 0) ? 10'd16 : (k == 1) ? 10'd32 : (k == 2) ? 10'd100 : 10'd1023;
         q_tgt = 3'(k);
         #0.1;
         check("R7 out of range", q_pend, q_src, 1'b0, 3'd0);
      end

      // R9: lookups change within one low phase
      @(negedge clk);
      q_id = 10'd9; q_tgt = 3'd2; #0.3;
      check("R9 same cycle a", q_pend, q_src, |model[9][2], lowest(model[9][2]));
      q_id = 10'd0; q_tgt = 3'd5; #0.3;
      check("R9 same cycle b", q_pend, q_src, |model[0][5], lowest(model[0][5]));

      // R2 R3 R4 R6 R10: pseudo-random operation mix
      for (int n = 0; n < 300; n++) begin
         op(1'($urandom), 3'($urandom), 4'($urandom), 8'($urandom),
            1'($urandom), 3'($urandom), 4'($urandom), 8'($urandom));
         sweep("R10 R6 random mix");
      end

      // R1: reset from a loaded state
      do_reset();
      sweep("R1 mid-run reset");

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule